// File: doc/BRIEF.md
# Cipher Buffer DMA Channel Pair

This block moves a memory buffer through a cipher engine with no software involvement once a transfer is programmed. A transmit side reads units from a source buffer and hands them to the cipher's input. A receive side takes units from the cipher's output and writes them to a destination buffer, which may be the same buffer as the source. Each side has a current address and count pair. It also has a second, queued pair that is loaded into the current one when the current count runs out. This lets two buffers be chained without a gap for reprogramming.

The size of each transfer is a byte, a half-word or a word, and the cipher's operating mode selects it. Counts are kept in transfer units, and addresses step by the unit size in bytes. The transmit side may run ahead of the receive side by no more than one cipher block, so the cipher never holds more than one block of data. Status flags show when the current count of each side is empty, and when both the current and the queued counts are empty.

Top module: `pdma_chan`

## Requirements
- R1: After reset, every address and count (current and queued, both sides) is zero, rd_req and wr_req are low, and tx_end, tx_all_done, rx_end and rx_all_done are high.
- R2: The mode input selects the transfer unit. Modes 0 to 4 (ECB, CBC, OFB, CFB-64, CFB-32) use a word, mode 5 (CFB-16) uses a half-word and mode 6 (CFB-8) uses a byte. rd_size and wr_size encode the unit as 0 for a byte, 1 for a half-word and 2 for a word.
- R3: Each granted read lowers tx_cnt by one and raises tx_ptr by the unit size in bytes. Each granted write does the same to rx_cnt and rx_ptr.
- R4: Reads are issued at tx_ptr and writes at rx_ptr. Read data goes to ci_data and cipher output goes to wr_data, right-aligned, so the destination receives the cipher's output in order. The source and destination may be the same buffer.
- R5: rd_req stays low while tx_cnt is zero, and wr_req stays low while rx_cnt is zero.
- R6: One cycle after a current count is zero while its queued count is nonzero, the queued address and count become current and the queued count becomes zero.
- R7: tx_end is high while tx_cnt is zero, and tx_all_done is high while both tx_cnt and tx_ncnt are zero. rx_end and rx_all_done are defined the same way on the receive side.
- R8: The bytes read minus the bytes written never exceed BLK_BYTES (8 by default). With writes stalled, reads stop once one block has been read.
- R9: A write with cfg_we high updates one register on the next clock edge. cfg_sel[2] picks the side (0 for transmit, 1 for receive), and cfg_sel[1:0] picks the field: 0 for the address, 1 for the count, 2 for the queued address and 3 for the queued count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Cipher operating mode, which selects the transfer unit |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: {side, field} |
| cfg_wdata | input | AW | Register write data |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Read byte address |
| rd_size | output | 2 | Read unit code |
| rd_gnt | input | 1 | Read grant; rd_data is valid in the same cycle |
| rd_data | input | DW | Read data, right-aligned |
| ci_valid | output | 1 | Unit presented to the cipher input |
| ci_data | output | DW | Cipher input data |
| ci_ready | input | 1 | Cipher can accept a unit |
| co_valid | input | 1 | Cipher output unit available |
| co_data | input | DW | Cipher output data |
| co_ready | output | 1 | Cipher output unit consumed |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Write byte address |
| wr_size | output | 2 | Write unit code |
| wr_data | output | DW | Write data, right-aligned |
| wr_gnt | input | 1 | Write grant |
| tx_ptr | output | AW | Current transmit address |
| tx_cnt | output | CW | Current transmit count in units |
| tx_ncnt | output | CW | Queued transmit count |
| rx_ptr | output | AW | Current receive address |
| rx_cnt | output | CW | Current receive count in units |
| rx_ncnt | output | CW | Queued receive count |
| tx_end | output | 1 | Transmit count empty |
| tx_all_done | output | 1 | Transmit count and queued count empty |
| rx_end | output | 1 | Receive count empty |
| rx_all_done | output | 1 | Receive count and queued count empty |

## Verification
The bench copies buffers in word, half-word and byte modes, with grants on an irregular pattern, and it also encrypts a buffer in place. If the mode-to-unit mapping or the address step were wrong, the destination bytes and the final addresses would not match. A chained transfer shows whether the queued pair is taken over: if the handover failed, the second destination would stay unwritten, or the queued count would stay set so that the all-done flag never rises. With writes held off, the bench counts the reads the block issues. A broken lead limit would either keep reading past one block or stop before the block was full.

// File: rtl/pdma_pkg.sv
// Shared definitions for the cipher buffer DMA channel pair.
// Assumes mode codes 0..6 as listed in the brief; code 7 is treated as word.
package pdma_pkg;
    typedef enum logic [2:0] {
        M_ECB   = 3'd0,
        M_CBC   = 3'd1,
        M_OFB   = 3'd2,
        M_CFB64 = 3'd3,
        M_CFB32 = 3'd4,
        M_CFB16 = 3'd5,
        M_CFB8  = 3'd6
    } cmode_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/pdma_unit.sv
// Maps the cipher mode to a transfer size code and a byte step.
// Purely combinational; assumes mode is held stable during a transfer.
module pdma_unit
    import pdma_pkg::*;
(
    input  logic [2:0] mode,
    output logic [1:0] size_code,
    output logic [2:0] step_bytes
);
    // Decode the mode into the unit size.
    always_comb begin
        case (cmode_e'(mode))
            M_CFB16: size_code = SZ_HALF;
            M_CFB8:  size_code = SZ_BYTE;
            default: size_code = SZ_WORD;
        endcase
        step_bytes = 3'd1 << size_code;
    end
endmodule

// File: rtl/pdma_dir.sv
// One direction of the channel: current address/count plus a queued pair.
// The count is in units; a completed transfer steps the address by step_bytes.
// Assumes done is only asserted while cnt is nonzero.
module pdma_dir #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    we,
    input  logic [AW-1:0] wdata,
    input  logic [2:0]    step_bytes,
    input  logic          done,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] ncnt
);
    logic [AW-1:0] nptr;
    logic          reload;

    // Handover is due when the current count is empty and a queued one exists.
    assign reload = (cnt == '0) && (ncnt != '0);

    // Register update: software write, then handover, then transfer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            cnt  <= '0;
            nptr <= '0;
            ncnt <= '0;
        end else begin
            if (we[0])       ptr <= wdata;
            else if (reload) ptr <= nptr;
            else if (done)   ptr <= ptr + AW'(step_bytes);

            if (we[1])       cnt <= wdata[CW-1:0];
            else if (reload) cnt <= ncnt;
            else if (done)   cnt <= cnt - CW'(1);

            if (we[2])       nptr <= wdata;

            if (we[3])       ncnt <= wdata[CW-1:0];
            else if (reload) ncnt <= '0;
        end
    end
endmodule

// File: rtl/pdma_lead.sv
// Tracks how many bytes the transmit side is ahead of the receive side
// and grants room for one more read only if that stays within one block.
module pdma_lead #(
    parameter int BLK_BYTES = 8,
    localparam int LW = $clog2(BLK_BYTES + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_done,
    input  logic          rx_done,
    input  logic [2:0]    step_bytes,
    output logic          room,
    output logic [LW-1:0] lead_bytes
);
    logic [LW-1:0] add_b;
    logic [LW-1:0] sub_b;

    // Byte deltas for this cycle.
    always_comb begin
        add_b = tx_done ? LW'(step_bytes) : '0;
        sub_b = rx_done ? LW'(step_bytes) : '0;
        room  = (lead_bytes + LW'(step_bytes)) <= LW'(BLK_BYTES);
    end

    // Running lead in bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) lead_bytes <= '0;
        else        lead_bytes <= lead_bytes + add_b - sub_b;
    end
endmodule

// File: rtl/pdma_chan.sv
// Cipher buffer DMA channel pair. The transmit side reads memory into the
// cipher; the receive side writes cipher output back to memory. Read data
// passes to the cipher in the grant cycle, and cipher output passes to the
// write bus in the grant cycle, so the block holds no data itself.
// Assumes mode is stable while either count is nonzero.
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int DW        = 32,
    parameter int BLK_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    input  logic          rd_gnt,
    input  logic [DW-1:0] rd_data,
    output logic          ci_valid,
    output logic [DW-1:0] ci_data,
    input  logic          ci_ready,
    input  logic          co_valid,
    input  logic [DW-1:0] co_data,
    output logic          co_ready,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [DW-1:0] wr_data,
    input  logic          wr_gnt,
    output logic [AW-1:0] tx_ptr,
    output logic [CW-1:0] tx_cnt,
    output logic [CW-1:0] tx_ncnt,
    output logic [AW-1:0] rx_ptr,
    output logic [CW-1:0] rx_cnt,
    output logic [CW-1:0] rx_ncnt,
    output logic          tx_end,
    output logic          tx_all_done,
    output logic          rx_end,
    output logic          rx_all_done
);
    localparam int NDIR = 2;
    localparam int LW   = $clog2(BLK_BYTES + 1) + 1;

    logic [1:0]    size_code;
    logic [2:0]    step_bytes;
    logic          room;
    logic [LW-1:0] lead_bytes;
    logic          tx_done;
    logic          rx_done;

    logic [NDIR-1:0]         done_a;
    logic [AW-1:0]           ptr_a  [NDIR];
    logic [CW-1:0]           cnt_a  [NDIR];
    logic [CW-1:0]           ncnt_a [NDIR];

    pdma_unit u_unit (
        .mode       (mode),
        .size_code  (size_code),
        .step_bytes (step_bytes)
    );

    assign done_a = {rx_done, tx_done};

    // One register set per side; side 0 is transmit, side 1 is receive.
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        logic [3:0] we_g;
        // Decode the register write for this side.
        always_comb begin
            we_g = '0;
            if (cfg_we && (cfg_sel[2] == g[0])) we_g[cfg_sel[1:0]] = 1'b1;
        end
        pdma_dir #(.AW(AW), .CW(CW)) u_dir (
            .clk        (clk),
            .rst_n      (rst_n),
            .we         (we_g),
            .wdata      (cfg_wdata),
            .step_bytes (step_bytes),
            .done       (done_a[g]),
            .ptr        (ptr_a[g]),
            .cnt        (cnt_a[g]),
            .ncnt       (ncnt_a[g])
        );
    end

    pdma_lead #(.BLK_BYTES(BLK_BYTES)) u_lead (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_done    (tx_done),
        .rx_done    (rx_done),
        .step_bytes (step_bytes),
        .room       (room),
        .lead_bytes (lead_bytes)
    );

    // Transmit path: read when units remain, the lead allows, and the cipher accepts.
    always_comb begin
        rd_req   = (cnt_a[0] != '0) && room && ci_ready;
        rd_addr  = ptr_a[0];
        rd_size  = size_code;
        tx_done  = rd_req && rd_gnt;
        ci_valid = tx_done;
        ci_data  = rd_data;
    end

    // Receive path: write cipher output while units remain.
    always_comb begin
        wr_req   = co_valid && (cnt_a[1] != '0);
        wr_addr  = ptr_a[1];
        wr_size  = size_code;
        wr_data  = co_data;
        rx_done  = wr_req && wr_gnt;
        co_ready = rx_done;
    end

    // Visible state and status flags.
    always_comb begin
        tx_ptr      = ptr_a[0];
        tx_cnt      = cnt_a[0];
        tx_ncnt     = ncnt_a[0];
        rx_ptr      = ptr_a[1];
        rx_cnt      = cnt_a[1];
        rx_ncnt     = ncnt_a[1];
        tx_end      = (cnt_a[0] == '0);
        tx_all_done = tx_end && (ncnt_a[0] == '0);
        rx_end      = (cnt_a[1] == '0);
        rx_all_done = rx_end && (ncnt_a[1] == '0);
    end
endmodule

// File: rtl/pdma_chan_chk.sv
// Property checker for pdma_chan, attached with bind below.
module pdma_chan_chk #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int BLK_BYTES = 8,
    parameter int LW        = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode,
    input logic          cfg_we,
    input logic          rd_req,
    input logic [1:0]    rd_size,
    input logic          rd_gnt,
    input logic          wr_req,
    input logic [AW-1:0] tx_ptr,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] tx_ncnt,
    input logic [CW-1:0] rx_cnt,
    input logic          rx_end,
    input logic          rx_all_done,
    input logic [LW-1:0] lead_bytes
);
    logic [1:0] exp_sz;
    logic [2:0] exp_ub;

    // Independent mode-to-unit expectation.
    always_comb begin
        case (mode)
            3'd5:    begin exp_sz = 2'd1; exp_ub = 3'd2; end
            3'd6:    begin exp_sz = 2'd0; exp_ub = 3'd1; end
            default: begin exp_sz = 2'd2; exp_ub = 3'd4; end
        endcase
    end

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0) |-> !rd_req);                                   // R5
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !wr_req);                                   // R5
    AST_SIZE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_size == exp_sz));                               // R2
    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_gnt && !cfg_we) |=>
        ((tx_cnt == $past(tx_cnt) - CW'(1)) &&
         (tx_ptr == $past(tx_ptr) + AW'($past(exp_ub)))));             // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_cnt == '0) && (tx_ncnt != '0) && !cfg_we) |=>
        ((tx_cnt == $past(tx_ncnt)) && (tx_ncnt == '0)));              // R6
    AST_LEAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lead_bytes <= LW'(BLK_BYTES));                                 // R8
    AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_all_done |-> rx_end);                                       // R7
endmodule

bind pdma_chan pdma_chan_chk #(
    .AW(AW), .CW(CW), .BLK_BYTES(BLK_BYTES), .LW(LW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .cfg_we      (cfg_we),
    .rd_req      (rd_req),
    .rd_size     (rd_size),
    .rd_gnt      (rd_gnt),
    .wr_req      (wr_req),
    .tx_ptr      (tx_ptr),
    .tx_cnt      (tx_cnt),
    .tx_ncnt     (tx_ncnt),
    .rx_cnt      (rx_cnt),
    .rx_end      (rx_end),
    .rx_all_done (rx_all_done),
    .lead_bytes  (lead_bytes)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          rd_req, rd_gnt;
    logic [AW-1:0] rd_addr, wr_addr, tx_ptr, rx_ptr;
    logic [1:0]    rd_size, wr_size;
    logic [DW-1:0] rd_data, ci_data, co_data, wr_data;
    logic          ci_valid, ci_ready, co_valid, co_ready, wr_req, wr_gnt;
    logic [CW-1:0] tx_cnt, tx_ncnt, rx_cnt, rx_ncnt;
    logic          tx_end, tx_all_done, rx_end, rx_all_done;

    int n_chk = 0;
    int n_bad = 0;
    int rd_beats = 0;
    int size_bad = 0;
    logic rnd_on = 1'b0;
    logic wr_hold = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]  mem [0:511];
    logic [31:0] fq  [0:15];
    logic [3:0]  fwp = '0, frp = '0;

    always #2 clk = ~clk;

    pdma_chan #(.AW(AW), .CW(CW), .DW(DW), .BLK_BYTES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_gnt(rd_gnt), .rd_data(rd_data), .ci_valid(ci_valid), .ci_data(ci_data),
        .ci_ready(ci_ready), .co_valid(co_valid), .co_data(co_data), .co_ready(co_ready),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .wr_gnt(wr_gnt), .tx_ptr(tx_ptr), .tx_cnt(tx_cnt), .tx_ncnt(tx_ncnt),
        .rx_ptr(rx_ptr), .rx_cnt(rx_cnt), .rx_ncnt(rx_ncnt), .tx_end(tx_end),
        .tx_all_done(tx_all_done), .rx_end(rx_end), .rx_all_done(rx_all_done)
    );

    function automatic int unit_of(input logic [2:0] m);
        if (m == 3'd5) return 2;
        if (m == 3'd6) return 1;
        return 4;
    endfunction

    function automatic logic [1:0] code_of(input logic [2:0] m);
        if (m == 3'd5) return 2'd1;
        if (m == 3'd6) return 2'd0;
        return 2'd2;
    endfunction

    // Bus grants and memory read model.
    assign rd_gnt   = rd_req & (rnd_on ? lfsr[0] : 1'b1);
    assign wr_gnt   = wr_req & ~wr_hold & (rnd_on ? lfsr[5] : 1'b1);
    assign ci_ready = 1'b1;
    assign co_valid = (fwp != frp);
    assign co_data  = fq[frp];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < 4; i++)
            if (i < (1 << rd_size)) rd_data[8*i +: 8] = mem[9'(rd_addr + 32'(i))];
    end

    // Memory writes, cipher stub queue, monitors.
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (wr_req && wr_gnt)
            for (int i = 0; i < 4; i++)
                if (i < (1 << wr_size)) mem[9'(wr_addr + 32'(i))] <= wr_data[8*i +: 8];
        if (ci_valid) begin
            fq[fwp] <= ci_data;
            fwp <= fwp + 4'd1;
        end
        if (co_valid && co_ready) frp <= frp + 4'd1;
        if (rd_req && rd_gnt) begin
            rd_beats <= rd_beats + 1;
            if (rd_size != code_of(mode)) size_bad <= size_bad + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill(input int base, input int nbytes, input int seed);
        for (int i = 0; i < nbytes; i++) mem[9'(base + i)] = 8'(seed * 7 + i * 13 + 1);
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (!(tx_all_done && rx_all_done) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(req, 64'(t < 3000), 64'd1);
    endtask

    // Copy a buffer and compare it against an expected image taken beforehand.
    task automatic t_copy(input string req, input logic [2:0] m, input int src,
                          input int dst, input int n, input logic rnd);
        logic [7:0] img [0:127];
        int ub = unit_of(m);
        int sb = size_bad;
        int bad = 0;
        mode = m; rnd_on = rnd;
        fill(src, n * ub, src + n);
        for (int i = 0; i < n * ub; i++) img[i] = mem[9'(src + i)];
        cfg(3'd0, 32'(src));
        cfg(3'd4, 32'(dst));
        cfg(3'd1, 32'(n));
        cfg(3'd5, 32'(n));
        wait_idle({req, " R7 finish"});
        for (int i = 0; i < n * ub; i++) if (mem[9'(dst + i)] !== img[i]) bad++;
        check({req, " R4 data"}, 64'(bad), 64'd0);
        check({req, " R3 tx_ptr"}, 64'(tx_ptr), 64'(src + n * ub));
        check({req, " R3 rx_ptr"}, 64'(rx_ptr), 64'(dst + n * ub));
        check({req, " R2 size"}, 64'(size_bad - sb), 64'd0);
        rnd_on = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 tx_cnt", 64'(tx_cnt), 64'd0);
        check("R1 rx_ncnt", 64'(rx_ncnt), 64'd0);
        check("R1 ptrs", 64'({tx_ptr, rx_ptr}), 64'd0);
        check("R1 reqs", 64'({rd_req, wr_req}), 64'd0);
        check("R1 flags", 64'({tx_end, tx_all_done, rx_end, rx_all_done}), 64'hF);
    endtask

    task automatic t_cfg_write;
        mode = 3'd0;
        cfg(3'd2, 32'h55);
        cfg(3'd4, 32'h1C0);
        check("R9 rx_ptr write", 64'(rx_ptr), 64'h1C0);
        check("R9 tx_cnt untouched", 64'(tx_cnt), 64'd0);
        check("R7 flags idle", 64'({tx_end, rx_all_done}), 64'h3);
    endtask

    task automatic t_chain;
        logic [7:0] img [0:31];
        int bad = 0;
        mode = 3'd1;
        fill(9'h000, 20, 3);
        for (int i = 0; i < 20; i++) img[i] = mem[9'(i)];
        cfg(3'd0, 32'h000);
        cfg(3'd2, 32'h00C);
        cfg(3'd4, 32'h100);
        cfg(3'd6, 32'h140);
        cfg(3'd1, 32'd3);
        cfg(3'd3, 32'd2);
        cfg(3'd5, 32'd3);
        cfg(3'd7, 32'd2);
        check("R7 rx_all_done low while queued", 64'(rx_all_done), 64'd0);
        wait_idle("R6 chain finish");
        for (int i = 0; i < 12; i++) if (mem[9'(32'h100 + i)] !== img[i]) bad++;
        for (int i = 0; i < 8; i++)  if (mem[9'(32'h140 + i)] !== img[12 + i]) bad++;
        check("R6 chained data", 64'(bad), 64'd0);
        check("R6 rx_ptr after chain", 64'(rx_ptr), 64'h148);
        check("R6 tx_ptr after chain", 64'(tx_ptr), 64'h014);
        check("R6 queued counts cleared", 64'({tx_ncnt, rx_ncnt}), 64'd0);
    endtask

    task automatic t_lead;
        int b0;
        logic [7:0] img [0:23];
        int bad = 0;
        mode = 3'd0; wr_hold = 1'b1;
        fill(9'h080, 24, 9);
        for (int i = 0; i < 24; i++) img[i] = mem[9'(32'h80 + i)];
        b0 = rd_beats;
        cfg(3'd0, 32'h080);
        cfg(3'd4, 32'h180);
        cfg(3'd1, 32'd6);
        cfg(3'd5, 32'd6);
        repeat (20) @(negedge clk);
        check("R8 reads stop at one block", 64'(rd_beats - b0), 64'd2);
        check("R8 rd_req low when full", 64'(rd_req), 64'd0);
        check("R3 tx_cnt after block", 64'(tx_cnt), 64'd4);
        wr_hold = 1'b0;
        wait_idle("R8 drain");
        for (int i = 0; i < 24; i++) if (mem[9'(32'h180 + i)] !== img[i]) bad++;
        check("R8 data after stall", 64'(bad), 64'd0);
    endtask

    task automatic t_idle;
        int b0 = rd_beats;
        repeat (10) @(negedge clk);
        check("R5 no reads when empty", 64'(rd_beats - b0), 64'd0);
        check("R5 no requests when empty", 64'({rd_req, wr_req}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cfg_write();
        t_copy("ECB word", 3'd0, 32'h000, 32'h100, 5, 1'b0);
        t_copy("CFB16 half", 3'd5, 32'h020, 32'h120, 7, 1'b1);
        t_copy("CFB8 byte", 3'd6, 32'h040, 32'h140, 11, 1'b1);
        t_copy("CFB32 word", 3'd4, 32'h060, 32'h160, 4, 1'b1);
        t_copy("CBC in place", 3'd1, 32'h0A0, 32'h0A0, 6, 1'b1);
        t_chain();
        t_lead();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule